// File: doc/BRIEF.md
# I/O Interrupt Router with Redirection Table

This block takes a bank of interrupt request lines from devices and turns each line event into an interrupt message for a processor. Every line has a redirection entry. The entry holds the vector, the delivery and destination mode, the destination ID, the trigger mode and a mask. Software reaches the entries, an identification register, a version register and an arbitration register through an indirect port. It writes a register index first and then reads or writes 32-bit data at that index.

Edge-mode lines produce one message for each rising edge. Level-mode lines use a remote-IRR handshake. The first message sets remote-IRR, and further messages on that line are held back until an end-of-interrupt (EOI) arrives with a matching vector. If the line is still high after that EOI, the line is delivered again. Messages leave through a valid/ready output register. When several lines compete, the lowest-numbered line wins.

Top module: `irq_router`

## Requirements
- R1: The identification register is at index 0x00 and resets to zero. Only bits 27:24 take written data. Every other bit reads zero whatever is written.
- R2: The version register is at index 0x01 and reads 0x00170011, which is version 0x11 in bits 7:0 and the number of lines minus one in bits 23:16. Writes to it have no effect.
- R3: The arbitration register is at index 0x02. Bits 27:24 are loaded with the same value on every write to index 0x00. Direct writes to index 0x02 are ignored.
- R4: Entry n has its low word at index 0x10+2n and its high word at index 0x10+2n+1. The low word has vector in bits 7:0, delivery mode in 10:8, destination mode in 11, remote-IRR in 14, trigger in 15 (1 = level) and mask in 16. The high word has the destination ID in bits 31:24. A high-word write changes only the destination and leaves vector, trigger and remote-IRR as they were.
- R5: Each rising edge of an unmasked edge-mode line produces exactly one message. The message carries the entry's vector and destination, with msg_level low.
- R6: A rising edge on a masked edge-mode line is dropped and is not delivered after the mask is cleared.
- R7: An asserted, unmasked level-mode line produces one message with msg_level high and sets remote-IRR. No further message is sent for that line while remote-IRR is set, even if the line toggles.
- R8: An EOI whose vector matches a level entry clears its remote-IRR. If the line is still high and the entry is unmasked, the line is delivered again with no software action on the mask.
- R9: A level line held high while masked is delivered when the mask is cleared. If the entry is masked again, then given an EOI and then unmasked with the line still high, it is delivered once more.
- R10: Remote-IRR reads zero after an EOI that follows deassertion of the line. Writes to the low word never change remote-IRR.
- R11: When several lines request at once, the lowest line number is sent first and the others stay pending. A message is held stable while msg_valid is high and msg_ready is low.
- R12: After reset every entry reads masked with all other fields zero (low word 0x00010000), the ID and arbitration registers read zero, and msg_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_LINES | Interrupt request lines, one per entry |
| idx_we | input | 1 | Load the register index |
| idx_wdata | input | IDX_W | New register index |
| data_we | input | 1 | Write data to the indexed register |
| data_wdata | input | 32 | Write data |
| data_rdata | output | 32 | Contents of the indexed register |
| msg_valid | output | 1 | An interrupt message is offered |
| msg_ready | input | 1 | The receiver accepts the message |
| msg_vector | output | 8 | Vector of the message |
| msg_dest | output | 8 | Destination ID |
| msg_dmode | output | 3 | Delivery mode |
| msg_destm | output | 1 | Destination mode |
| msg_level | output | 1 | 1 when the message comes from a level-mode entry |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector of the interrupt being ended |

## Verification
A remote-IRR bit stuck high shows up at the ports as a level line that never delivers again after its EOI. A bit that fails to set shows up as a second message within two cycles of a line toggle. Both are visible in bit 14 of the low word as soon as the entry is read. A lost or doubled edge-pending bit changes the message count two cycles after the edge. Wrong arbitration shows in the vector of the first message presented while msg_ready is held low. Write-permission faults in the ID, version and arbitration registers show on the next read of the affected index.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int          NUM_LINES = 24,
  parameter int          IDX_W     = 8,
  parameter logic [7:0]  VERSION   = 8'h11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 idx_we,
  input  logic [IDX_W-1:0]     idx_wdata,
  input  logic                 data_we,
  input  logic [31:0]          data_wdata,
  output logic [31:0]          data_rdata,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [7:0]           msg_vector,
  output logic [7:0]           msg_dest,
  output logic [2:0]           msg_dmode,
  output logic                 msg_destm,
  output logic                 msg_level,
  input  logic                 eoi_valid,
  input  logic [7:0]           eoi_vector
);
  localparam int              LW       = $clog2(NUM_LINES);
  localparam logic [IDX_W-1:0] TBL_BASE = IDX_W'(16);
  localparam logic [IDX_W-1:0] TBL_SPAN = IDX_W'(2 * NUM_LINES);
  localparam logic [IDX_W-1:0] IDX_ID   = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_VER  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_ARB  = IDX_W'(2);
  localparam logic [7:0]      MAX_ENT  = 8'(NUM_LINES - 1);

  logic [IDX_W-1:0]     idx_q;
  logic [3:0]           id_q, arb_q;
  logic [7:0]           vec_q   [NUM_LINES];
  logic [7:0]           dest_q  [NUM_LINES];
  logic [2:0]           dmode_q [NUM_LINES];
  logic [NUM_LINES-1:0] destm_q, trig_q, mask_q, rirr_q, prev_q, epend_q;

  logic [IDX_W-1:0] tbl_off;
  logic             sel_tbl, sel_hi;
  logic [LW-1:0]    ent;

  assign tbl_off = idx_q - TBL_BASE;
  assign sel_tbl = (idx_q >= TBL_BASE) && (tbl_off < TBL_SPAN);
  assign sel_hi  = tbl_off[0];
  assign ent     = tbl_off[LW:1];

  always_comb begin
    data_rdata = '0;
    if (idx_q == IDX_ID)
      data_rdata[27:24] = id_q;
    else if (idx_q == IDX_VER)
      data_rdata = {8'h00, MAX_ENT, 8'h00, VERSION};
    else if (idx_q == IDX_ARB)
      data_rdata[27:24] = arb_q;
    else if (sel_tbl) begin
      if (sel_hi)
        data_rdata = {dest_q[ent], 24'h0};
      else
        data_rdata = {15'h0, mask_q[ent], trig_q[ent], rirr_q[ent], 2'b00,
                      destm_q[ent], dmode_q[ent], vec_q[ent]};
    end
  end

  logic [NUM_LINES-1:0] rise, req, grant;
  logic [LW-1:0]        win;
  logic                 load;

  assign rise = irq_lines & ~prev_q;
  assign req  = ((~trig_q & epend_q) | (trig_q & irq_lines & ~rirr_q)) & ~mask_q;

  always_comb begin
    grant = '0;
    win   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        win = LW'(i);
      end
    end
  end

  assign load = (|req) && (!msg_valid || msg_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      id_q      <= '0;
      arb_q     <= '0;
      destm_q   <= '0;
      trig_q    <= '0;
      mask_q    <= '1;
      rirr_q    <= '0;
      prev_q    <= '0;
      epend_q   <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        vec_q[i]   <= '0;
        dest_q[i]  <= '0;
        dmode_q[i] <= '0;
      end
      msg_valid  <= 1'b0;
      msg_vector <= '0;
      msg_dest   <= '0;
      msg_dmode  <= '0;
      msg_destm  <= 1'b0;
      msg_level  <= 1'b0;
    end else begin
      if (idx_we) idx_q <= idx_wdata;
      if (data_we) begin
        if (idx_q == IDX_ID) begin
          id_q  <= data_wdata[27:24];
          arb_q <= data_wdata[27:24];
        end else if (sel_tbl) begin
          if (sel_hi)
            dest_q[ent] <= data_wdata[31:24];
          else begin
            vec_q[ent]   <= data_wdata[7:0];
            dmode_q[ent] <= data_wdata[10:8];
            destm_q[ent] <= data_wdata[11];
            trig_q[ent]  <= data_wdata[15];
            mask_q[ent]  <= data_wdata[16];
          end
        end
      end
      prev_q <= irq_lines;
      for (int i = 0; i < NUM_LINES; i++) begin
        epend_q[i] <= (epend_q[i] && !(load && grant[i]))
                      || (rise[i] && !trig_q[i] && !mask_q[i]);
        if (load && grant[i] && trig_q[i])
          rirr_q[i] <= 1'b1;
        else if (eoi_valid && trig_q[i] && vec_q[i] == eoi_vector)
          rirr_q[i] <= 1'b0;
      end
      if (load) begin
        msg_valid  <= 1'b1;
        msg_vector <= vec_q[win];
        msg_dest   <= dest_q[win];
        msg_dmode  <= dmode_q[win];
        msg_destm  <= destm_q[win];
        msg_level  <= trig_q[win];
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end

  // R11
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector)
                                   && $stable(msg_dest) && $stable(msg_level)));

  // R3
  arb_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && idx_q == IDX_ARB) |=> $stable(arb_q));

  // R1
  arb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && idx_q == IDX_ID) |=> (arb_q == id_q && id_q == $past(data_wdata[27:24])));

  // R7
  rirr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && trig_q[win]) |=> (rirr_q[$past(win)] && msg_level));

endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic        idx_we = 1'b0;
  logic [7:0]  idx_wdata = '0;
  logic        data_we = 1'b0;
  logic [31:0] data_wdata = '0;
  logic [31:0] data_rdata;
  logic        msg_valid, msg_ready = 1'b1;
  logic [7:0]  msg_vector, msg_dest;
  logic [2:0]  msg_dmode;
  logic        msg_destm, msg_level;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;

  always #5 clk = ~clk;

  irq_router #(.NUM_LINES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq),
    .idx_we(idx_we), .idx_wdata(idx_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_dmode(msg_dmode),
    .msg_destm(msg_destm), .msg_level(msg_level),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector));

  int checks = 0, fails = 0, n_msg = 0;
  logic [7:0] last_vec = '0, last_dest = '0;
  logic last_lvl = 1'b0;
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      n_msg++;
      last_vec  = msg_vector;
      last_dest = msg_dest;
      last_lvl  = msg_level;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] idx, logic [31:0] d);
    idx_we = 1'b1; idx_wdata = idx; tick(1); idx_we = 1'b0;
    data_we = 1'b1; data_wdata = d; tick(1); data_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] idx, output logic [31:0] d);
    idx_we = 1'b1; idx_wdata = idx; tick(1); idx_we = 1'b0;
    d = data_rdata;
  endtask

  task automatic eoi(logic [7:0] v);
    eoi_valid = 1'b1; eoi_vector = v; tick(1); eoi_valid = 1'b0; tick(5);
  endtask

  task automatic pulse(int l);
    irq[l] = 1'b1; tick(2); irq[l] = 1'b0; tick(5);
  endtask

  function automatic logic [31:0] lo_word(logic [7:0] v, bit lvl, bit msk, bit rirr);
    return {15'h0, msk, lvl, rirr, 6'h0, v};
  endfunction

  function automatic logic [7:0] lo_idx(int l);
    return 8'(16 + 2 * l);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int base;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R12 reset state
    check(msg_valid == 1'b0, "R12 no message", {31'h0, msg_valid}, 32'h0);
    rd(lo_idx(0), d);  check(d == 32'h00010000, "R12 entry0", d, 32'h00010000);
    rd(lo_idx(23), d); check(d == 32'h00010000, "R12 entry23", d, 32'h00010000);
    rd(8'h00, d); check(d == 32'h0, "R12 id", d, 32'h0);
    rd(8'h02, d); check(d == 32'h0, "R12 arb", d, 32'h0);

    // R2 version
    rd(8'h01, d); check(d == 32'h00170011, "R2 version", d, 32'h00170011);
    wr(8'h01, ~32'h00170011);
    rd(8'h01, d); check(d == 32'h00170011, "R2 version ro", d, 32'h00170011);

    // R1 R3 id and arbitration
    wr(8'h00, 32'hFFFFFFFF);
    rd(8'h00, d); check(d == 32'h0F000000, "R1 id mask", d, 32'h0F000000);
    rd(8'h02, d); check(d == 32'h0F000000, "R3 arb follows", d, 32'h0F000000);
    wr(8'h02, 32'h0);
    rd(8'h02, d); check(d == 32'h0F000000, "R3 arb ro", d, 32'h0F000000);

    // R5 edge delivery
    base = n_msg;
    wr(lo_idx(14), lo_word(8'h76, 0, 0, 0));
    pulse(14);
    check(n_msg == base + 1, "R5 edge count", 32'(n_msg - base), 32'd1);
    check(last_vec == 8'h76 && !last_lvl, "R5 edge vector", {23'h0, last_lvl, last_vec}, 32'h76);

    // R6 masked edge dropped
    base = n_msg;
    wr(lo_idx(14), lo_word(8'h81, 0, 1, 0));
    pulse(14);
    wr(lo_idx(14), lo_word(8'h81, 0, 0, 0));
    tick(5);
    check(n_msg == base, "R6 masked edge dropped", 32'(n_msg - base), 32'd0);
    pulse(14);
    check(n_msg == base + 1 && last_vec == 8'h81, "R6 unmasked edge", 32'(n_msg - base), 32'd1);

    // R7 R8 R10 level handshake
    base = n_msg;
    wr(lo_idx(14), lo_word(8'h77, 1, 0, 0));
    irq[14] = 1'b1; tick(5);
    check(n_msg == base + 1 && last_lvl, "R7 level delivery", 32'(n_msg - base), 32'd1);
    rd(lo_idx(14), d); check(d == lo_word(8'h77, 1, 0, 1), "R7 rirr set", d, lo_word(8'h77, 1, 0, 1));
    irq[14] = 1'b0; tick(2); irq[14] = 1'b1; tick(5);
    check(n_msg == base + 1, "R7 coalesce", 32'(n_msg - base), 32'd1);
    eoi(8'h55);
    check(n_msg == base + 1, "R8 wrong vector eoi", 32'(n_msg - base), 32'd1);
    eoi(8'h77);
    check(n_msg == base + 2 && last_vec == 8'h77, "R8 redelivery", 32'(n_msg - base), 32'd2);
    irq[14] = 1'b0; tick(2);
    eoi(8'h77);
    check(n_msg == base + 2, "R10 no extra", 32'(n_msg - base), 32'd2);
    rd(lo_idx(14), d); check(d == lo_word(8'h77, 1, 0, 0), "R10 rirr clear", d, lo_word(8'h77, 1, 0, 0));

    // R9 masked level
    base = n_msg;
    wr(lo_idx(14), lo_word(8'h82, 1, 1, 0));
    irq[14] = 1'b1; tick(5);
    check(n_msg == base, "R9 masked level held", 32'(n_msg - base), 32'd0);
    wr(lo_idx(14), lo_word(8'h82, 1, 0, 0)); tick(5);
    check(n_msg == base + 1 && last_vec == 8'h82, "R9 unmask delivers", 32'(n_msg - base), 32'd1);
    wr(lo_idx(14), lo_word(8'h82, 1, 1, 0));
    eoi(8'h82);
    check(n_msg == base + 1, "R9 remasked", 32'(n_msg - base), 32'd1);
    wr(lo_idx(14), lo_word(8'h82, 1, 0, 0)); tick(5);
    check(n_msg == base + 2, "R9 second delivery", 32'(n_msg - base), 32'd2);
    irq[14] = 1'b0; tick(2);
    eoi(8'h82);

    // R4 high word write keeps low fields
    wr(lo_idx(14), lo_word(8'h84, 1, 0, 0));
    irq[14] = 1'b1; tick(5);
    wr(lo_idx(14) + 8'd1, 32'h01000000);
    rd(lo_idx(14), d); check(d == lo_word(8'h84, 1, 0, 1), "R4 low unchanged", d, lo_word(8'h84, 1, 0, 1));
    rd(lo_idx(14) + 8'd1, d); check(d == 32'h01000000, "R4 dest", d, 32'h01000000);
    irq[14] = 1'b0; tick(2);
    eoi(8'h84);
    rd(lo_idx(14), d); check(d == lo_word(8'h84, 1, 0, 0), "R10 rirr after eoi", d, lo_word(8'h84, 1, 0, 0));
    base = n_msg;
    wr(lo_idx(14), lo_word(8'h85, 0, 0, 0));
    pulse(14);
    check(n_msg == base + 1 && last_dest == 8'h01, "R4 dest in message", {24'h0, last_dest}, 32'h01);

    // R10 rirr read-only through low word
    wr(lo_idx(14), lo_word(8'h85, 0, 1, 1));
    rd(lo_idx(14), d); check(d == lo_word(8'h85, 0, 1, 0), "R10 rirr ro", d, lo_word(8'h85, 0, 1, 0));

    // R11 lowest line first, held while not ready
    base = n_msg;
    wr(lo_idx(14), lo_word(8'h78, 0, 0, 0));
    wr(lo_idx(15), lo_word(8'h66, 0, 0, 0));
    msg_ready = 1'b0;
    irq[14] = 1'b1; irq[15] = 1'b1; tick(4);
    check(msg_valid && msg_vector == 8'h78, "R11 lowest first", {24'h0, msg_vector}, 32'h78);
    tick(3);
    check(msg_valid && msg_vector == 8'h78, "R11 held stable", {24'h0, msg_vector}, 32'h78);
    msg_ready = 1'b1; tick(5);
    check(n_msg == base + 2 && last_vec == 8'h66, "R11 second pending", {24'h0, last_vec}, 32'h66);
    irq[14] = 1'b0; irq[15] = 1'b0; tick(2);
    wr(lo_idx(14), lo_word(8'h78, 0, 1, 0));
    wr(lo_idx(15), lo_word(8'h66, 0, 1, 0));

    // R5 random edge traffic
    void'($urandom(32'h1d2c));
    for (int k = 0; k < 30; k++) begin
      int l;
      logic [7:0] v, ds;
      l  = int'($urandom_range(0, N - 1));
      v  = 8'($urandom_range(32, 255));
      ds = 8'($urandom);
      base = n_msg;
      wr(lo_idx(l) + 8'd1, {ds, 24'h0});
      wr(lo_idx(l), lo_word(v, 0, 0, 0));
      pulse(l);
      check(n_msg == base + 1 && last_vec == v && last_dest == ds && !last_lvl,
            "R5 random edge", {last_dest, last_vec, 8'(n_msg - base), 7'h0, last_lvl},
            {ds, v, 8'd1, 8'h0});
      wr(lo_idx(l), lo_word(v, 0, 1, 0));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule